// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block is the host side of a two-wire serial debug link. On request it produces the debug clock and drives or releases the bidirectional data line, so that it can issue one read or one write to a debug-port or access-port register. A command is the port/access selector, the read/write flag, a two-bit register address and, for writes, a 32-bit word. When the frame has finished the engine returns the three acknowledge bits, the word that was read, a parity-error flag and a flag for a target that did not answer. The same engine can also send a line-reset sequence.

Frames always start from a low line. The engine clocks a programmable number of low idle bits before every start bit. It drives the park bit high itself, so the weak pull-up on the line only has to keep it high through the turnaround. Some targets present their acknowledge one bit early, and a configuration input moves the turnaround bits to suit them: the turnaround before the acknowledge is removed and a second one is added after it. The total frame length does not change.

The debug clock is derived from the system clock. Each bit lasts four phases of `PHASE_CYCLES` clocks: two low, then two high. The host changes its output one phase after the falling edge. It samples the target on the last system clock before the next falling edge, which leaves the target free to change its data on the rising edge.

Top module: `swd_host_engine`

## Requirements
- R1: While not busy, `swclk` is low, `swdio_oe` is 1 and `swdio_out` is 0. Every request begins with `IDLE_BITS` (default 2) clocked low bits before its start bit, and this also holds for a request issued directly after a line reset.
- R2: The request header is 8 host-driven bits, sent in this order: start = 1, `cmd_apndp`, `cmd_rnw`, `cmd_addr[0]`, `cmd_addr[1]`, the even parity of those four bits, stop = 0, park.
- R3: During the park bit the host drives the line (`swdio_oe` = 1) with the value 1.
- R4: With `cfg_early_ack` = 0, one released turnaround bit follows park. Then three acknowledge bits are sampled, and the first one received lands in `rsp_ack[0]`. OK is 3'b001.
- R5: A write acknowledged OK continues with one turnaround bit, then 32 driven data bits sent LSB first, then their even-parity bit. From start bit to parity bit the frame is 46 SWCLK rising edges.
- R6: A read acknowledged OK samples 32 data bits LSB first, then a parity bit, directly after the acknowledge, and ends with one turnaround bit. `rsp_rdata` returns the word. `rsp_parity_err` is 1 exactly when the received parity bit differs from the XOR of the data bits.
- R7: For any other acknowledge, such as WAIT (3'b010) or FAULT (3'b100), the data phase is skipped. One turnaround bit follows, the line is then driven low, and `rsp_ack` reports the received value. `rsp_rdata` is 0 in this case.
- R8: An acknowledge of 3'b111 means the target did not answer. `rsp_no_resp` is then 1 when `done` is asserted; for any other acknowledge it is 0.
- R9: With `cfg_early_ack` = 1 (sampled when the command is accepted), the acknowledge starts in the bit right after park. Two turnaround bits follow the acknowledge: before the write data, after the read parity bit, or at the end of a non-OK frame. Frames therefore keep their nominal length.
- R10: Each bit lasts 4*`PHASE_CYCLES` clocks, with SWCLK low for the first half and high for the second. The host changes `swdio_out` and `swdio_oe` only `PHASE_CYCLES` clocks after a falling edge. `swdio_in` is sampled on the last clock before the falling edge. SWCLK stays low between frames.
- R11: `line_reset` sends `RESET_BITS` (default 50) driven high bits, then `RESET_IDLE` (default 2) low bits. After a line reset, `rsp_ack` reads 0.
- R12: `busy` is 1 from the cycle after a start is accepted until `done`. `done` is a one-cycle pulse, and in that same cycle the line is back to driven low. `line_reset` wins over `cmd_start` when both are high, and both are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start a register access (taken when idle) |
| line_reset | input | 1 | Start a line-reset sequence (taken when idle) |
| cmd_apndp | input | 1 | 1 selects an access port, 0 the debug port |
| cmd_rnw | input | 1 | 1 read, 0 write |
| cmd_addr | input | 2 | Register address bits 3:2 |
| cmd_wdata | input | 32 | Write data |
| cfg_early_ack | input | 1 | Select early-acknowledge turnaround placement |
| swdio_in | input | 1 | Value sensed on the data line |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rsp_ack | output | 3 | Received acknowledge |
| rsp_rdata | output | 32 | Received read data |
| rsp_parity_err | output | 1 | Read parity mismatch |
| rsp_no_resp | output | 1 | Acknowledge was 3'b111 |
| swclk | output | 1 | Debug clock |
| swdio_out | output | 1 | Value driven on the data line |
| swdio_oe | output | 1 | Output enable for the data line |

## Verification
On every cycle, the assertions check that the host output changes only while SWCLK is low, that the line is held low with the clock stopped whenever the engine is idle, that the start and park bits are driven high, that the line is released during the acknowledge, and that `done` lasts one cycle. The bench's scenarios are what show frame content and bit placement. They cover the header order and parity, the two turnaround placements, the read data and parity-error result, the skipped data phase after WAIT or FAULT, the no-response flag, the 46-edge frame length and the line-reset pattern.

// File: rtl/swd_pkg.sv
package swd_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RST_HI,
      ST_RST_LO,
      ST_PRE,
      ST_HDR,
      ST_TRN_PRE,
      ST_ACK,
      ST_RDATA,
      ST_TRN_POST,
      ST_WDATA,
      ST_FIN
   } seq_state_t;

   localparam logic [2:0] ACK_OK    = 3'b001;
   localparam logic [2:0] ACK_WAIT  = 3'b010;
   localparam logic [2:0] ACK_FAULT = 3'b100;
   localparam logic [2:0] ACK_NONE  = 3'b111;

   localparam int HDR_BITS  = 8;
   localparam int DATA_BITS = 32;
   localparam int ACK_BITS  = 3;
endpackage

// File: rtl/swd_bit_timer.sv
module swd_bit_timer #(
   parameter int PHASE_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic swclk,
   output logic drive_stb,
   output logic end_stb
);
   logic [1:0] phase;

   generate
      if (PHASE_CYCLES == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   phase <= 2'd0;
            else if (!run) phase <= 2'd0;
            else          phase <= phase + 2'd1;
         end
         assign drive_stb = run && (phase == 2'd0);
         assign end_stb   = run && (phase == 2'd3);
      end else begin : g_prescale
         localparam int PW = $clog2(PHASE_CYCLES);
         localparam logic [PW-1:0] PRE_LAST = PW'(PHASE_CYCLES - 1);
         logic [PW-1:0] pre;
         logic          pre_wrap;
         assign pre_wrap = (pre == PRE_LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre   <= '0;
               phase <= 2'd0;
            end else if (!run) begin
               pre   <= '0;
               phase <= 2'd0;
            end else if (pre_wrap) begin
               pre   <= '0;
               phase <= phase + 2'd1;
            end else begin
               pre   <= pre + 1'b1;
            end
         end
         assign drive_stb = run && pre_wrap && (phase == 2'd0);
         assign end_stb   = run && pre_wrap && (phase == 2'd3);
      end
   endgenerate

   assign swclk = phase[1];

   initial begin
      assert (PHASE_CYCLES >= 1) else $error("PHASE_CYCLES must be at least 1");
   end
endmodule

// File: rtl/swd_rx_capture.sv
module swd_rx_capture #(
   parameter int DATA_BITS = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear,
   input  logic                 ack_stb,
   input  logic                 data_stb,
   input  logic                 bit_in,
   output logic [2:0]           ack_q,
   output logic [DATA_BITS-1:0] rdata,
   output logic                 par_err
);
   localparam int FRAME_BITS = DATA_BITS + 1;
   logic [FRAME_BITS-1:0] sreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q <= '0;
         sreg  <= '0;
      end else if (clear) begin
         ack_q <= '0;
         sreg  <= '0;
      end else begin
         if (ack_stb)  ack_q <= {bit_in, ack_q[2:1]};
         if (data_stb) sreg  <= {bit_in, sreg[FRAME_BITS-1:1]};
      end
   end

   assign rdata   = sreg[DATA_BITS-1:0];
   assign par_err = ^sreg;

   AST_NO_DUAL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack_stb && data_stb)); // R6
endmodule

// File: rtl/swd_frame_seq.sv
module swd_frame_seq
   import swd_pkg::*;
#(
   parameter int IDLE_BITS  = 2,
   parameter int RESET_BITS = 50,
   parameter int RESET_IDLE = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_cmd,
   input  logic                 start_reset,
   input  logic                 cfg_early,
   input  logic                 cmd_apndp,
   input  logic                 cmd_rnw,
   input  logic [1:0]           cmd_addr,
   input  logic [DATA_BITS-1:0] cmd_wdata,
   input  logic                 drive_stb,
   input  logic                 end_stb,
   input  logic                 swdio_in,
   input  logic [1:0]           ack_hi,
   output logic                 busy,
   output logic                 done,
   output logic                 swdio_out,
   output logic                 swdio_oe,
   output logic                 rx_clear,
   output logic                 ack_stb,
   output logic                 data_stb
);
   localparam int M1   = (RESET_BITS > IDLE_BITS) ? RESET_BITS : IDLE_BITS;
   localparam int M2   = (M1 > RESET_IDLE) ? M1 : RESET_IDLE;
   localparam int MAXB = (M2 > DATA_BITS + 1) ? M2 : DATA_BITS + 1;
   localparam int CNT_W = $clog2(MAXB + 1);
   localparam logic [CNT_W-1:0] LAST_IDLE = CNT_W'(IDLE_BITS - 1);
   localparam logic [CNT_W-1:0] LAST_RHI  = CNT_W'(RESET_BITS - 1);
   localparam logic [CNT_W-1:0] LAST_RLO  = CNT_W'(RESET_IDLE - 1);
   localparam logic [CNT_W-1:0] LAST_HDR  = CNT_W'(HDR_BITS - 1);
   localparam logic [CNT_W-1:0] LAST_ACK  = CNT_W'(ACK_BITS - 1);
   localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_BITS);

   seq_state_t             state;
   logic [CNT_W-1:0]       bcnt;
   logic [HDR_BITS-1:0]    hdr_q;
   logic [DATA_BITS:0]     wbits_q;
   logic                   rnw_q, early_q, to_wdata_q;
   logic [2:0]             ack_now;
   logic [CNT_W-1:0]       last_trn;

   assign busy     = (state != ST_IDLE);
   assign rx_clear = (state == ST_IDLE) && (start_cmd || start_reset);
   assign ack_stb  = (state == ST_ACK) && end_stb;
   assign data_stb = (state == ST_RDATA) && end_stb;
   assign ack_now  = {swdio_in, ack_hi};
   assign last_trn = early_q ? CNT_W'(1) : CNT_W'(0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         bcnt       <= '0;
         hdr_q      <= '0;
         wbits_q    <= '0;
         rnw_q      <= 1'b0;
         early_q    <= 1'b0;
         to_wdata_q <= 1'b0;
         swdio_out  <= 1'b0;
         swdio_oe   <= 1'b1;
         done       <= 1'b0;
      end else begin
         done <= 1'b0;
         if (state == ST_IDLE) begin
            bcnt <= '0;
            if (start_reset) begin
               state <= ST_RST_HI;
            end else if (start_cmd) begin
               state   <= ST_PRE;
               rnw_q   <= cmd_rnw;
               early_q <= cfg_early;
               hdr_q   <= {1'b1, 1'b0, ^{cmd_apndp, cmd_rnw, cmd_addr},
                           cmd_addr[1], cmd_addr[0], cmd_rnw, cmd_apndp, 1'b1};
               wbits_q <= {^cmd_wdata, cmd_wdata};
            end
         end else begin
            if (drive_stb) begin
               unique case (state)
                  ST_RST_HI:  begin swdio_oe <= 1'b1; swdio_out <= 1'b1;       end
                  ST_RST_LO,
                  ST_PRE:     begin swdio_oe <= 1'b1; swdio_out <= 1'b0;       end
                  ST_HDR:     begin swdio_oe <= 1'b1; swdio_out <= hdr_q[0];   end
                  ST_WDATA:   begin swdio_oe <= 1'b1; swdio_out <= wbits_q[0]; end
                  ST_TRN_PRE,
                  ST_ACK,
                  ST_RDATA,
                  ST_TRN_POST: swdio_oe <= 1'b0;
                  ST_FIN: begin
                     swdio_oe  <= 1'b1;
                     swdio_out <= 1'b0;
                     done      <= 1'b1;
                     state     <= ST_IDLE;
                  end
                  default: ;
               endcase
            end
            if (end_stb) begin
               bcnt <= bcnt + 1'b1;
               unique case (state)
                  ST_RST_HI: if (bcnt == LAST_RHI) begin
                     state <= ST_RST_LO; bcnt <= '0;
                  end
                  ST_RST_LO: if (bcnt == LAST_RLO) begin
                     state <= ST_FIN; bcnt <= '0;
                  end
                  ST_PRE: if (bcnt == LAST_IDLE) begin
                     state <= ST_HDR; bcnt <= '0;
                  end
                  ST_HDR: begin
                     hdr_q <= hdr_q >> 1;
                     if (bcnt == LAST_HDR) begin
                        state <= early_q ? ST_ACK : ST_TRN_PRE;
                        bcnt  <= '0;
                     end
                  end
                  ST_TRN_PRE: begin
                     state <= ST_ACK; bcnt <= '0;
                  end
                  ST_ACK: if (bcnt == LAST_ACK) begin
                     bcnt <= '0;
                     if (ack_now == ACK_OK && rnw_q) begin
                        state <= ST_RDATA;
                     end else begin
                        state      <= ST_TRN_POST;
                        to_wdata_q <= (ack_now == ACK_OK);
                     end
                  end
                  ST_RDATA: if (bcnt == LAST_DATA) begin
                     state      <= ST_TRN_POST;
                     to_wdata_q <= 1'b0;
                     bcnt       <= '0;
                  end
                  ST_TRN_POST: if (bcnt == last_trn) begin
                     state <= to_wdata_q ? ST_WDATA : ST_FIN;
                     bcnt  <= '0;
                  end
                  ST_WDATA: begin
                     wbits_q <= wbits_q >> 1;
                     if (bcnt == LAST_DATA) begin
                        state <= ST_FIN; bcnt <= '0;
                     end
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   AST_START_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HDR && bcnt == '0 && drive_stb) |=> (swdio_oe && swdio_out)); // R2
   AST_PARK_DRIVEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HDR && bcnt == LAST_HDR && drive_stb) |=> (swdio_oe && swdio_out)); // R3
   AST_ACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACK && drive_stb) |=> !swdio_oe); // R4
   AST_WDATA_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WDATA && drive_stb) |=> swdio_oe); // R5
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R12

   initial begin
      assert (IDLE_BITS >= 1)   else $error("IDLE_BITS must be at least 1");
      assert (RESET_BITS >= 50) else $error("RESET_BITS must be at least 50");
      assert (RESET_IDLE >= 2)  else $error("RESET_IDLE must be at least 2");
   end
endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine
   import swd_pkg::*;
#(
   parameter int PHASE_CYCLES = 2,
   parameter int IDLE_BITS    = 2,
   parameter int RESET_BITS   = 50,
   parameter int RESET_IDLE   = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_start,
   input  logic        line_reset,
   input  logic        cmd_apndp,
   input  logic        cmd_rnw,
   input  logic [1:0]  cmd_addr,
   input  logic [31:0] cmd_wdata,
   input  logic        cfg_early_ack,
   input  logic        swdio_in,
   output logic        busy,
   output logic        done,
   output logic [2:0]  rsp_ack,
   output logic [31:0] rsp_rdata,
   output logic        rsp_parity_err,
   output logic        rsp_no_resp,
   output logic        swclk,
   output logic        swdio_out,
   output logic        swdio_oe
);
   logic drive_stb, end_stb, rx_clear, ack_stb, data_stb;
   logic [2:0] ack_q;

   swd_bit_timer #(.PHASE_CYCLES(PHASE_CYCLES)) timer_i (
      .clk(clk), .rst_n(rst_n), .run(busy), .swclk(swclk),
      .drive_stb(drive_stb), .end_stb(end_stb)
   );

   swd_frame_seq #(
      .IDLE_BITS(IDLE_BITS), .RESET_BITS(RESET_BITS), .RESET_IDLE(RESET_IDLE)
   ) seq_i (
      .clk(clk), .rst_n(rst_n), .start_cmd(cmd_start), .start_reset(line_reset),
      .cfg_early(cfg_early_ack), .cmd_apndp(cmd_apndp), .cmd_rnw(cmd_rnw),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .drive_stb(drive_stb),
      .end_stb(end_stb), .swdio_in(swdio_in), .ack_hi(ack_q[2:1]),
      .busy(busy), .done(done), .swdio_out(swdio_out), .swdio_oe(swdio_oe),
      .rx_clear(rx_clear), .ack_stb(ack_stb), .data_stb(data_stb)
   );

   swd_rx_capture #(.DATA_BITS(DATA_BITS)) rx_i (
      .clk(clk), .rst_n(rst_n), .clear(rx_clear), .ack_stb(ack_stb),
      .data_stb(data_stb), .bit_in(swdio_in), .ack_q(ack_q),
      .rdata(rsp_rdata), .par_err(rsp_parity_err)
   );

   assign rsp_ack     = ack_q;
   assign rsp_no_resp = (ack_q == ACK_NONE);

   AST_DATA_CHANGES_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(swdio_out) || !$stable(swdio_oe)) |-> !swclk); // R10
   AST_CLK_STOPPED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !swclk); // R10
   AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (swdio_oe && !swdio_out)); // R1
endmodule

// File: tb/swd_host_engine_tb.sv
module swd_host_engine_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int PH   = 2;
   localparam int IDLE = 2;
   localparam int RB   = 50;
   localparam int RI   = 2;
   localparam int BITC = 4 * PH;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_start = 1'b0, line_reset = 1'b0, cmd_apndp = 1'b0, cmd_rnw = 1'b0;
   logic [1:0] cmd_addr = 2'b00;
   logic [31:0] cmd_wdata = '0;
   logic cfg_early_ack = 1'b0, swdio_in = 1'b1;
   logic busy, done, rsp_parity_err, rsp_no_resp, swclk, swdio_out, swdio_oe;
   logic [2:0] rsp_ack;
   logic [31:0] rsp_rdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   swd_host_engine #(.PHASE_CYCLES(PH), .IDLE_BITS(IDLE), .RESET_BITS(RB),
                     .RESET_IDLE(RI)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .line_reset(line_reset),
      .cmd_apndp(cmd_apndp), .cmd_rnw(cmd_rnw), .cmd_addr(cmd_addr),
      .cmd_wdata(cmd_wdata), .cfg_early_ack(cfg_early_ack), .swdio_in(swdio_in),
      .busy(busy), .done(done), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
      .rsp_parity_err(rsp_parity_err), .rsp_no_resp(rsp_no_resp),
      .swclk(swclk), .swdio_out(swdio_out), .swdio_oe(swdio_oe)
   );

   typedef struct packed {
      logic       oe;
      logic       val;
      logic       tgt;
      logic [3:0] req;
   } bit_t;

   bit_t q[$];
   int errors = 0, checks = 0, cyc = 0;
   logic [2:0]  e_ack;
   logic [31:0] e_rdata;
   logic        e_perr, e_nr;

   task automatic check(input int req, input logic [63:0] act, input logic [63:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic oe, input logic val, input logic tgt, input int req);
      bit_t b;
      b.oe = oe; b.val = val; b.tgt = tgt; b.req = 4'(req);
      q.push_back(b);
   endtask

   // Expected bit stream of a register access (R1, R2, R3, R4, R5, R6, R7, R9)
   task automatic build_cmd(input logic ap, input logic rnw, input logic [1:0] a,
                            input logic [31:0] wd, input logic [2:0] ack,
                            input logic [31:0] rd, input logic badpar, input logic early);
      logic ok;
      int ntrn;
      logic [7:0] hdr;
      q.delete();
      ok   = (ack == 3'b001);
      ntrn = early ? 2 : 1;
      hdr  = {1'b1, 1'b0, ap ^ rnw ^ a[0] ^ a[1], a[1], a[0], rnw, ap, 1'b1};
      for (int i = 0; i < IDLE; i++) push(1, 0, 1, 1);            // R1
      for (int i = 0; i < 8; i++) push(1, hdr[i], 1, (i == 7) ? 3 : 2); // R2 R3
      if (!early) push(0, 0, 1, 4);                               // R4
      for (int i = 0; i < 3; i++) push(0, 0, ack[i], early ? 9 : 4);
      if (ok && !rnw) begin
         for (int i = 0; i < ntrn; i++) push(0, 0, 1, early ? 9 : 5);
         for (int i = 0; i < 32; i++) push(1, wd[i], 1, 5);       // R5
         push(1, ^wd, 1, 5);
      end else if (ok && rnw) begin
         for (int i = 0; i < 32; i++) push(0, 0, rd[i], 6);       // R6
         push(0, 0, (^rd) ^ badpar, 6);
         for (int i = 0; i < ntrn; i++) push(0, 0, 1, early ? 9 : 6);
      end else begin
         for (int i = 0; i < ntrn; i++) push(0, 0, 1, early ? 9 : 7); // R7
      end
      e_ack   = ack;
      e_rdata = (ok && rnw) ? rd : 32'h0;
      e_perr  = ok && rnw && badpar;
      e_nr    = (ack == 3'b111);                                  // R8
      cmd_apndp = ap; cmd_rnw = rnw; cmd_addr = a; cmd_wdata = wd; cfg_early_ack = early;
   endtask

   // Expected bit stream of a line reset (R11)
   task automatic build_reset();
      q.delete();
      for (int i = 0; i < RB; i++) push(1, 1, 1, 11);
      for (int i = 0; i < RI; i++) push(1, 0, 1, 11);
      e_ack = 3'b000; e_rdata = 32'h0; e_perr = 1'b0; e_nr = 1'b0;
   endtask

   // Cycle-by-cycle comparison against the reference model (R10, R12)
   task automatic run_frame(input logic s_cmd, input logic s_rst, input logic inject,
                            output int rises);
      int n, t, b, p;
      logic prev_clk;
      bit_t cur;
      logic e_clk, e_oe, e_val, e_busy, e_done;
      rises = 0;
      prev_clk = 1'b0;
      @(negedge clk);
      cmd_start = s_cmd; line_reset = s_rst;
      @(negedge clk);
      cmd_start = 1'b0; line_reset = 1'b0;
      n = q.size();
      t = n * BITC + PH;
      for (int k = 0; k <= t; k++) begin
         b = k / BITC;
         p = k % BITC;
         if (p >= 2 * PH && b < n) swdio_in = q[b].tgt;
         else if (b > 0)          swdio_in = q[b-1].tgt;
         else                     swdio_in = 1'b1;
         if (inject && k == 40) begin cmd_start = 1'b1; line_reset = 1'b1; end
         if (inject && k == 41) begin cmd_start = 1'b0; line_reset = 1'b0; end
         e_clk = (k < n * BITC) && (p >= 2 * PH);
         if (k == t)                     begin e_oe = 1; e_val = 0; end
         else if (p >= PH && b < n)      begin cur = q[b];   e_oe = cur.oe; e_val = cur.val; end
         else if (b > 0)                 begin cur = q[b-1]; e_oe = cur.oe; e_val = cur.val; end
         else                            begin e_oe = 1; e_val = 0; end
         e_busy = (k < t);
         e_done = (k == t);
         check((b < n) ? int'(q[b].req) : 12,
               {59'd0, swclk, swdio_oe, swdio_oe & swdio_out & e_oe, busy, done},
               {59'd0, e_clk, e_oe, e_val & e_oe, e_busy, e_done},
               $sformatf("cycle %0d clk/oe/out/busy/done", k));
         if (swclk && !prev_clk) rises++;
         prev_clk = swclk;
         if (k == t) begin
            check(e_nr ? 8 : 7, {61'd0, rsp_ack}, {61'd0, e_ack}, "rsp_ack");
            check(6, {32'd0, rsp_rdata}, {32'd0, e_rdata}, "rsp_rdata");
            check(6, {63'd0, rsp_parity_err}, {63'd0, e_perr}, "rsp_parity_err");
            check(8, {63'd0, rsp_no_resp}, {63'd0, e_nr}, "rsp_no_resp");
         end
         @(negedge clk);
      end
      swdio_in = 1'b1;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         checks++;
         $display("FAIL R12 watchdog: actual=running expected=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int r;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(1, {60'd0, busy, swclk, swdio_oe, swdio_out}, {60'd0, 4'b0010}, "reset state");

      // R11 line reset; R12 priority over a simultaneous cmd_start
      build_reset();
      run_frame(1, 1, 0, r);
      check(11, 64'(r), 64'(RB + RI), "line reset rising edges");

      // R5 nominal write, OK, right after line reset (R1)
      build_cmd(0, 0, 2'b01, 32'hC3A5_0F96, 3'b001, 0, 0, 0);
      run_frame(1, 0, 0, r);
      check(5, 64'(r), 64'(IDLE + 46), "write frame rising edges");

      // R6 nominal read, OK, good parity
      build_cmd(1, 1, 2'b10, 0, 3'b001, 32'hA5C3_1E07, 0, 0);
      run_frame(1, 0, 0, r);
      check(6, 64'(r), 64'(IDLE + 46), "read frame rising edges");

      // R6 read with corrupted parity
      build_cmd(0, 1, 2'b11, 0, 3'b001, 32'h0000_8001, 1, 0);
      run_frame(1, 0, 0, r);

      // R7 WAIT on write, FAULT on read
      build_cmd(1, 0, 2'b00, 32'hFFFF_0000, 3'b010, 0, 0, 0);
      run_frame(1, 0, 0, r);
      build_cmd(0, 1, 2'b01, 0, 3'b100, 32'h1234_5678, 0, 0);
      run_frame(1, 0, 0, r);
      check(7, 64'(r), 64'(IDLE + 13), "fault frame rising edges");

      // R8 no response
      build_cmd(1, 0, 2'b10, 32'h5555_AAAA, 3'b111, 0, 0, 0);
      run_frame(1, 0, 0, r);

      // R9 early acknowledge placement: write, read, fault
      build_cmd(1, 0, 2'b11, 32'h8765_4321, 3'b001, 0, 0, 1);
      run_frame(1, 0, 0, r);
      check(9, 64'(r), 64'(IDLE + 46), "early write rising edges");
      build_cmd(0, 1, 2'b00, 0, 3'b001, 32'hDEAD_BEEF, 0, 1);
      run_frame(1, 0, 0, r);
      check(9, 64'(r), 64'(IDLE + 46), "early read rising edges");
      build_cmd(1, 1, 2'b01, 0, 3'b100, 32'h0, 0, 1);
      run_frame(1, 0, 0, r);

      // R12 starts while busy are ignored
      build_cmd(0, 0, 2'b10, 32'h0F0F_F0F0, 3'b001, 0, 0, 0);
      run_frame(1, 0, 1, r);
      for (int i = 0; i < 8; i++) begin
         check(12, {61'd0, busy, swclk, done}, 64'd0, "idle after ignored start");
         @(negedge clk);
      end

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule